// File: doc/BRIEF.md
# In-Place Serial Add-Compare-Select Unit

This block updates the 64 path metrics of a constraint-length-7, rate-1/4 convolutional code. It works one butterfly at a time, using one add-compare-select datapath and one path-metric memory. Each symbol update starts with a pulse on `sym_valid`. The unit then reads the two old metrics of every butterfly one after the other from a single memory. It asks the branch-metric unit for the branch metrics that the butterfly needs. It writes the smaller candidate sum back for the even successor first and the odd successor second.

The new metrics go back into the same two memory words that the old ones came from. This works because the addresses come from rotating the logical slot index right by the current stage, which is held in a one-hot counter. The pattern repeats every six symbols. A survivor decision is produced for every state and leaves the block in 16-bit slices. The unit also finds the best state of each symbol and rescales all metrics once they have all grown past a threshold.

Top module: `serial_acs`

## Requirements
- R1: After reset the outputs `busy`, `sym_done` and `dec_valid` are low, all 64 path metrics are zero, and the stage index is zero.
- R2: For new state n = {b,h} (b = n>>1, h = n&1), the predecessors are {0,b} and {1,b}. Both sums use the code word c = `bm_sel`, where bit j is the XOR of window bits w[i] at the set bits i of polynomial j. The window is w = {0,b,0}: w[0] is the input bit and w[6:1] is the predecessor. The polynomials, in octal for j = 0..3, are 133, 171, 145 and 133. For h = 0 the sums are pm{0,b} + `bm_match` and pm{1,b} + `bm_comp`. For h = 1 the two branch metrics are swapped. The new metric is the smaller sum.
- R3: The decision bit is 1 when the {1,b} candidate is strictly smaller. A tie gives decision 0.
- R4: Each symbol yields four slices. In slice j, bit i is the decision of state 16j+i, and `dec_idx` = j. Slice j is presented with `dec_valid` in the cycle after the (19+16j)-th rising edge that follows the accepting edge.
- R5: `sym_done` pulses for one cycle after the 68th rising edge that follows the accepting edge. At that point `best_state` and `best_metric` hold the smallest new metric of the symbol, and a tie goes to the lowest state index.
- R6: If every new metric of a symbol is at least NORM_THR (128), then every metric of the next symbol has NORM_THR subtracted after the selection.
- R7: A new metric larger than 255 is stored as 255.
- R8: `busy` is high from the accepting edge until `sym_done`. A `sym_valid` that arrives while `busy` is high is ignored.
- R9: Metrics stay consistent across symbols as the stage rotates, including after the six-symbol address pattern wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Start a symbol update (taken when idle) |
| bm_sel | output | 4 | Code word of the butterfly in the ACS stage |
| bm_match | input | BMW | Branch metric of code word `bm_sel` |
| bm_comp | input | BMW | Branch metric of the complement of `bm_sel` |
| busy | output | 1 | Update in progress |
| dec_valid | output | 1 | Decision slice valid |
| dec_idx | output | 2 | Slice index |
| dec_seg | output | 16 | Decision slice |
| sym_done | output | 1 | Symbol update finished |
| best_state | output | 6 | Best state of the last symbol |
| best_metric | output | 8 | Metric of that state |

## Verification
The unit accepts a symbol at the edge that samples `sym_valid`. Slice j then appears 19+16j edges later, and `sym_done` appears exactly 68 edges later. The bench counts edges from the accepting edge and samples at the falling edge. It checks the cycle number of every slice and of the done pulse against these values, not just their contents. The branch-metric unit is modelled by the bench as a combinational lookup that stays fixed for the whole symbol. The expected metrics are carried forward in a logical-state model of the bench's own, so an error in the address rotation shows up in later symbols.

// File: rtl/vacs_pkg.sv
// Shared defaults of the serial ACS unit: code definition constants.
// Assumes every polynomial taps both the newest and the oldest window bit.
package vacs_pkg;
    localparam int DEF_K     = 7;
    localparam int DEF_NPOLY = 4;
    // polynomial j sits at bits [j*K +: K]; j=0 is 133 octal
    localparam logic [DEF_NPOLY*DEF_K-1:0] DEF_POLYS = {7'o133, 7'o145, 7'o171, 7'o133};
endpackage

// File: rtl/acs_addr_gen.sv
// Slot counter and in-place address generator.
// Walks 2^SW slots per symbol; the logical slot {half, butterfly} is rotated
// right by the stage held in a one-hot register. Assumes start only when idle.
module acs_addr_gen #(
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stage_adv,
    output logic          issuing,
    output logic [SW-1:0] cnt,
    output logic [SW-1:0] rd_addr
);
    logic [SW-1:0] stage_oh;
    logic [SW-1:0] slot;
    logic [SW-1:0] rot [SW];

    // slot counter: one read per cycle for 2^SW cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            issuing <= 1'b1;
            cnt     <= '0;
        end else if (issuing) begin
            cnt <= cnt + 1'b1;
            if (&cnt) issuing <= 1'b0;
        end
    end

    // one-hot stage ring, advanced after the last write of a symbol
    always_ff @(posedge clk) begin
        if (!rst_n) stage_oh <= SW'(1);
        else if (stage_adv) stage_oh <= {stage_oh[SW-2:0], stage_oh[SW-1]};
    end

    assign slot = {cnt[0], cnt[SW-1:1]};

    for (genvar k = 0; k < SW; k++) begin : g_rot
        logic [2*SW-1:0] dbl;
        assign dbl    = {slot, slot};
        assign rot[k] = dbl[k +: SW];
    end

    // one-hot selected rotation
    always_comb begin
        rd_addr = '0;
        for (int k = 0; k < SW; k++)
            if (stage_oh[k]) rd_addr = rd_addr | rot[k];
    end
endmodule

// File: rtl/acs_pm_mem.sv
// Path-metric store: one synchronous read port, one write port, cleared by reset.
// Assumes the in-place schedule never reads a word in the cycle it is written.
module acs_pm_mem #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // storage write and reset clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // registered read
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

    assert_rw_distinct_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (rd_addr != wr_addr));
endmodule

// File: rtl/acs_core.sv
// Butterfly datapath: holds the two old metrics of a butterfly for two cycles,
// forms both candidate sums, selects, normalizes and clamps. Assumes BMW <= PMW.
module acs_core #(
    parameter int K        = 7,
    parameter int NPOLY    = 4,
    parameter logic [NPOLY*K-1:0] POLYS = vacs_pkg::DEF_POLYS,
    parameter int BMW      = 5,
    parameter int PMW      = 8,
    parameter int NORM_THR = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PMW-1:0]   rd_data,
    input  logic             cap_lo,
    input  logic             cap_pair,
    input  logic             acs_v,
    input  logic             acs_half,
    input  logic [K-3:0]     acs_bfly,
    input  logic             norm_on,
    input  logic [BMW-1:0]   bm_match,
    input  logic [BMW-1:0]   bm_comp,
    output logic [NPOLY-1:0] bm_sel,
    output logic [PMW-1:0]   new_pm,
    output logic             dec
);
    localparam int SUMW  = PMW + 1;
    localparam int MAXPM = (1 << PMW) - 1;

    logic [PMW-1:0]  hold_lo, pm_a, pm_b;
    logic [K-1:0]    win;
    logic [BMW-1:0]  bm_a, bm_b;
    logic [SUMW-1:0] sum_a, sum_b, pick, adj;

    // capture the low metric, then the pair, which stays for two cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_lo <= '0;
            pm_a    <= '0;
            pm_b    <= '0;
        end else begin
            if (cap_lo) hold_lo <= rd_data;
            if (cap_pair) begin
                pm_a <= hold_lo;
                pm_b <= rd_data;
            end
        end
    end

    assign win = {1'b0, acs_bfly, 1'b0};
    for (genvar j = 0; j < NPOLY; j++) begin : g_code
        assign bm_sel[j] = ^(win & POLYS[j*K +: K]);
    end

    // add, compare, select, normalize, clamp
    always_comb begin
        bm_a   = acs_half ? bm_comp : bm_match;
        bm_b   = acs_half ? bm_match : bm_comp;
        sum_a  = {1'b0, pm_a} + SUMW'(bm_a);
        sum_b  = {1'b0, pm_b} + SUMW'(bm_b);
        dec    = sum_b < sum_a;
        pick   = dec ? sum_b : sum_a;
        adj    = norm_on ? pick - SUMW'(NORM_THR) : pick;
        new_pm = (adj > SUMW'(MAXPM)) ? PMW'(MAXPM) : adj[PMW-1:0];
    end

    assert_norm_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acs_v && norm_on) |-> (pick >= SUMW'(NORM_THR)));
endmodule

// File: rtl/serial_acs.sv
// State-serial in-place ACS unit. Five-cycle pipeline: read issue, low hold,
// pair hold, ACS, write-back. Emits decisions in slices, tracks the best state,
// and schedules normalization. Assumes branch metrics answer combinationally.
module serial_acs #(
    parameter int K        = vacs_pkg::DEF_K,
    parameter int NPOLY    = vacs_pkg::DEF_NPOLY,
    parameter logic [NPOLY*K-1:0] POLYS = vacs_pkg::DEF_POLYS,
    parameter int BMW      = 5,
    parameter int PMW      = 8,
    parameter int SEGW     = 16,
    parameter int NORM_THR = 128,
    localparam int SW      = K - 1,
    localparam int NST     = 1 << SW,
    localparam int SEGB    = $clog2(SEGW),
    localparam int SEGIW   = $clog2(NST / SEGW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    output logic [NPOLY-1:0] bm_sel,
    input  logic [BMW-1:0]   bm_match,
    input  logic [BMW-1:0]   bm_comp,
    output logic             busy,
    output logic             dec_valid,
    output logic [SEGIW-1:0] dec_idx,
    output logic [SEGW-1:0]  dec_seg,
    output logic             sym_done,
    output logic [SW-1:0]    best_state,
    output logic [PMW-1:0]   best_metric
);
    localparam int PIPE = 4;

    logic            issuing, start_ok, last_wr, norm_on, all_ge, dec, take;
    logic [SW-1:0]   cnt, rd_addr, run_s;
    logic [PMW-1:0]  rd_data, new_pm, wr_pm, run_m;
    logic [PIPE-1:0] sr_v;
    logic [SW-1:0]   sr_cnt  [PIPE];
    logic [SW-1:0]   sr_addr [PIPE];
    logic [SEGW-1:0] dshift;

    assign busy     = issuing | (|sr_v);
    assign start_ok = sym_valid & ~busy;
    assign last_wr  = sr_v[PIPE-1] & (&sr_cnt[PIPE-1]);
    assign take     = (sr_cnt[PIPE-1] == '0) || (wr_pm < run_m);

    acs_addr_gen #(.SW(SW)) i_addr (
        .clk(clk), .rst_n(rst_n), .start(start_ok), .stage_adv(last_wr),
        .issuing(issuing), .cnt(cnt), .rd_addr(rd_addr));

    acs_pm_mem #(.AW(SW), .DW(PMW)) i_mem (
        .clk(clk), .rst_n(rst_n), .rd_en(issuing), .rd_addr(rd_addr),
        .wr_en(sr_v[PIPE-1]), .wr_addr(sr_addr[PIPE-1]), .wr_data(wr_pm),
        .rd_data(rd_data));

    acs_core #(.K(K), .NPOLY(NPOLY), .POLYS(POLYS), .BMW(BMW), .PMW(PMW),
               .NORM_THR(NORM_THR)) i_core (
        .clk(clk), .rst_n(rst_n), .rd_data(rd_data),
        .cap_lo(sr_v[0] & ~sr_cnt[0][0]), .cap_pair(sr_v[0] & sr_cnt[0][0]),
        .acs_v(sr_v[PIPE-2]), .acs_half(sr_cnt[PIPE-2][0]),
        .acs_bfly(sr_cnt[PIPE-2][SW-1:1]), .norm_on(norm_on),
        .bm_match(bm_match), .bm_comp(bm_comp), .bm_sel(bm_sel),
        .new_pm(new_pm), .dec(dec));

    // token pipeline carrying slot count and address to write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_v  <= '0;
            wr_pm <= '0;
            for (int k = 0; k < PIPE; k++) begin
                sr_cnt[k]  <= '0;
                sr_addr[k] <= '0;
            end
        end else begin
            sr_v       <= {sr_v[PIPE-2:0], issuing};
            sr_cnt[0]  <= cnt;
            sr_addr[0] <= rd_addr;
            for (int k = 1; k < PIPE; k++) begin
                sr_cnt[k]  <= sr_cnt[k-1];
                sr_addr[k] <= sr_addr[k-1];
            end
            if (sr_v[PIPE-2]) wr_pm <= new_pm;
        end
    end

    // decision slices: bit i of a slice is state slice*SEGW+i
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dshift    <= '0;
            dec_valid <= 1'b0;
            dec_idx   <= '0;
            dec_seg   <= '0;
        end else begin
            dec_valid <= 1'b0;
            if (sr_v[PIPE-2]) begin
                dshift <= {dec, dshift[SEGW-1:1]};
                if (&sr_cnt[PIPE-2][SEGB-1:0]) begin
                    dec_valid <= 1'b1;
                    dec_seg   <= {dec, dshift[SEGW-1:1]};
                    dec_idx   <= sr_cnt[PIPE-2][SW-1:SEGB];
                end
            end
        end
    end

    // best-state search, normalization flag and done pulse at write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_s       <= '0;
            run_m       <= '0;
            all_ge      <= 1'b0;
            norm_on     <= 1'b0;
            sym_done    <= 1'b0;
            best_state  <= '0;
            best_metric <= '0;
        end else begin
            sym_done <= last_wr;
            if (sr_v[PIPE-1]) begin
                if (take) begin
                    run_s <= sr_cnt[PIPE-1];
                    run_m <= wr_pm;
                end
                all_ge <= ((sr_cnt[PIPE-1] == '0) || all_ge) && (wr_pm >= PMW'(NORM_THR));
            end
            if (last_wr) begin
                best_state  <= take ? sr_cnt[PIPE-1] : run_s;
                best_metric <= take ? wr_pm : run_m;
                norm_on     <= all_ge && (wr_pm >= PMW'(NORM_THR));
            end
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_done |=> !sym_done);
    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !busy) |=> busy);
    assert_seg_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> busy);
    assert_pair_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_v[PIPE-1] && sr_cnt[PIPE-1][0]) |->
        ($countones(sr_addr[PIPE-1] ^ $past(sr_addr[PIPE-1])) == 1));
endmodule

// File: tb/test_serial_acs.sv
module test_serial_acs;
    localparam int THR = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [3:0]  bm_sel;
    logic [7:0]  bm_match, bm_comp;
    logic        busy, dec_valid, sym_done;
    logic [1:0]  dec_idx;
    logic [15:0] dec_seg;
    logic [5:0]  best_state;
    logic [7:0]  best_metric;

    logic [7:0]  bm_tab [16];
    int          pm [64];
    bit          norm_m = 0;
    int          checks = 0, fails = 0;
    int          cyc = 0;
    bit          ended = 0;
    logic [6:0]  polys [4] = '{7'o133, 7'o171, 7'o145, 7'o133};

    always #10 clk = ~clk;

    assign bm_match = bm_tab[bm_sel];
    assign bm_comp  = bm_tab[~bm_sel];

    serial_acs #(.BMW(8), .NORM_THR(THR)) i_serial_acs (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .bm_sel(bm_sel),
        .bm_match(bm_match), .bm_comp(bm_comp), .busy(busy),
        .dec_valid(dec_valid), .dec_idx(dec_idx), .dec_seg(dec_seg),
        .sym_done(sym_done), .best_state(best_state), .best_metric(best_metric));

    function automatic logic [3:0] enc(input int b);
        logic [6:0] w;
        logic [3:0] c;
        w = {1'b0, 5'(b), 1'b0};
        for (int j = 0; j < 4; j++) c[j] = ^(w & polys[j]);
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_sym(input bit poke, input string req);
        logic [63:0] exp_dec;
        int          npm [64];
        int          bs, bmn, n, segs;
        bit          seen, allge;
        logic [3:0]  c0, ca, cb;
        bs = 0; bmn = 1 << 30; allge = 1;
        for (int s = 0; s < 64; s++) begin
            int b, h, sa, sb, mn;
            b = s >> 1; h = s & 1;
            c0 = enc(b);
            ca = h ? ~c0 : c0;
            cb = h ? c0 : ~c0;
            sa = pm[b] + int'(bm_tab[ca]);
            sb = pm[b + 32] + int'(bm_tab[cb]);
            exp_dec[s] = sb < sa;
            mn = (sb < sa) ? sb : sa;
            if (norm_m) mn -= THR;
            if (mn > 255) mn = 255;
            npm[s] = mn;
            if (mn < bmn) begin bmn = mn; bs = s; end
            if (mn < THR) allge = 0;
        end
        @(negedge clk) sym_valid = 1'b1;
        @(posedge clk);
        @(negedge clk) sym_valid = 1'b0;
        n = 0; seen = 0; segs = 0;
        while (!seen && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            sym_valid = (poke && n == 10);
            if (n == 1) chk(busy === 1'b1, "R8", int'(busy), 1, "busy after accept");
            if (dec_valid) begin
                chk(n == 19 + 16 * int'(dec_idx), "R4", n, 19 + 16 * int'(dec_idx), "slice timing");
                chk(dec_seg === exp_dec[int'(dec_idx)*16 +: 16], req, int'(dec_seg),
                    int'(exp_dec[int'(dec_idx)*16 +: 16]), "slice decisions (R2 R3 R4)");
                segs++;
            end
            if (sym_done) seen = 1;
        end
        chk(n == 68, "R5", n, 68, "done cycle");
        chk(segs == 4, "R4", segs, 4, "slice count");
        chk(best_state === 6'(bs), "R5", int'(best_state), bs, "best state");
        chk(best_metric === 8'(bmn), req, int'(best_metric), bmn, "best metric (R5)");
        @(posedge clk);
        @(negedge clk);
        chk(sym_done === 1'b0 && busy === 1'b0, "R8", int'(sym_done) + int'(busy), 0, "idle after done");
        for (int s = 0; s < 64; s++) pm[s] = npm[s];
        norm_m = allge;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !ended) begin
                fails++;
                $display("FAIL R5 watchdog: actual %0d expected %0d", cyc, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < 64; s++) pm[s] = 0;
        for (int i = 0; i < 16; i++) bm_tab[i] = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs
        chk(busy === 1'b0, "R1", int'(busy), 0, "busy after reset");
        chk(sym_done === 1'b0, "R1", int'(sym_done), 0, "done after reset");
        chk(dec_valid === 1'b0, "R1", int'(dec_valid), 0, "dec_valid after reset");
        // R1 R3: zero metrics and zero branch metrics: all ties, decision 0
        run_sym(0, "R1");
        // R2 R9: random symbols, past the six-stage wrap; one with a start while busy (R8)
        for (int k = 0; k < 14; k++) begin
            for (int i = 0; i < 16; i++) bm_tab[i] = 8'($urandom_range(0, 40));
            run_sym(k == 3, k < 6 ? "R2" : "R9");
        end
        // R6: equal metrics climb past the threshold, then get rescaled
        for (int i = 0; i < 16; i++) bm_tab[i] = 8'd40;
        for (int k = 0; k < 7; k++) run_sym(0, "R6");
        // R7: one cheap code word, all others costly: metrics clamp at 255
        for (int i = 0; i < 16; i++) bm_tab[i] = 8'd255;
        bm_tab[0] = 8'd0;
        for (int k = 0; k < 4; k++) run_sym(0, "R7");
        for (int i = 0; i < 16; i++) bm_tab[i] = 8'($urandom_range(0, 60));
        for (int k = 0; k < 3; k++) run_sym(0, "R7");
        // R3: ties on random metrics
        for (int i = 0; i < 16; i++) bm_tab[i] = 8'd7;
        run_sym(0, "R3");
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 16; i++) bm_tab[i] = 8'($urandom_range(0, 30));
            run_sym(0, "R9");
        end
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule